// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's memory request interface and a single-ported memory. Stores from the processor go into a small FIFO and are returned to the processor as accepted at once. They are written to memory later, in the order they arrived, whenever the memory port is not needed for anything else. Loads are handled first. Each load address is compared with the addresses of every store still in the buffer. If a store matches, the load gets its value straight from the buffer and memory is not touched. If nothing matches, the load goes to memory at once, ahead of any buffered stores, which all have other addresses.

A load that matches more than one buffered store gets the value of the most recently accepted one. A store accepted in the same cycle as a load counts as younger than that load. Only one memory read can be outstanding at a time. An ordering unit that needs all earlier stores to be visible in memory can wait for the empty output to go high.

Top module: `store_fwd_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it is released, empty is 1, st_ready is 1, ld_ready is 1, ld_rsp_valid is 0 and mem_req is 0.
- R2: A store is accepted in a cycle where st_valid and st_ready are both 1. Every accepted store appears exactly once on the memory port as a write (mem_req=1, mem_we=1, completed by mem_ready=1), with its own address and data. Writes appear in the order the stores were accepted.
- R3: st_ready is 0 while DEPTH stores are held. A store offered in such a cycle is not taken. If it is held on the port, it is accepted in the first cycle after an entry leaves the buffer.
- R4: A load is accepted when ld_valid and ld_ready are both 1. If its address equals a buffered entry's address, ld_rsp_valid=1 and ld_rsp_hit=1 in the next cycle. The response data is that of the youngest matching entry, and no memory read is issued for the load.
- R5: A load that matches no entry drives a read (mem_req=1, mem_we=0, mem_addr = load address) starting in the cycle it is accepted, and holds it until mem_ready=1. In the cycle after that, ld_rsp_valid=1, ld_rsp_hit=0, and the response data is the mem_rdata seen with mem_ready.
- R6: In a cycle where a memory read is pending or just issued, the port carries that read and no buffered store is written.
- R7: A missing load may complete while older stores to other addresses are still in the buffer (empty=0 when its response appears).
- R8: empty is 1 exactly when the buffer holds no entries.
- R9: ld_ready is 0 from the cycle after a missing load is accepted until the cycle after its read completes. A store accepted in the same cycle as a load is not forwarded to that load.
- R10: With no read on the port and at least one entry held, the port carries a write of the oldest entry every cycle. The entry leaves in each cycle where mem_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | No memory read outstanding |
| ld_addr | input | ADDR_W | Load address |
| ld_rsp_valid | output | 1 | Load response present |
| ld_rsp_data | output | DATA_W | Load response data |
| ld_rsp_hit | output | 1 | Response came from the buffer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory completes the current access |
| empty | output | 1 | No stores held |

## Verification
The hardest situation to reach is a full buffer that holds several stores to the same address while a load to that address is accepted. That load has to pick the youngest copy. A second load then misses and stalls on the memory port, and it must overtake the older writes. The stimulus holds mem_ready low so that the buffer fills, and then puts in loads with repeated and fresh addresses. After that, a long pseudo-random phase mixes loads, stores, and gaps in memory readiness over a small address range, so that hits, misses and drains overlap. A behavioural queue model predicts every port value on every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_WRITE = 2'd2
  } port_use_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  input  logic [PTR_W-1:0]              rd_idx,
  output logic [DATA_W-1:0]             rd_data,
  output logic [DATA_W-1:0]             head_data,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [PTR_W-1:0]              head_ptr,
  output logic [CNT_W-1:0]              count,
  output logic [DEPTH-1:0][ADDR_W-1:0]  addr_vec
);
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // data storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_addr_out
    assign addr_vec[g] = addr_q[g];
  end

  assign rd_data   = data_q[rd_idx];
  assign head_data = data_q[head_q];
  assign head_addr = addr_q[head_q];
  assign head_ptr  = head_q;
  assign count     = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count_q != CNT_W'(DEPTH)));  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));  // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_W'(DEPTH) && !pop) |=> (count_q == CNT_W'(DEPTH)));  // R3
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_vec,
  input  logic [PTR_W-1:0]             head_ptr,
  input  logic [CNT_W-1:0]             count,
  input  logic [ADDR_W-1:0]            q_addr,
  output logic                         hit,
  output logic [PTR_W-1:0]             sel_idx
);
  logic [PTR_W-1:0] idx;

  // walk from oldest to youngest; the last match found is the youngest
  always_comb begin
    hit     = 1'b0;
    sel_idx = '0;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PTR_W'(k);
      if ((CNT_W'(k) < count) && (addr_vec[idx] == q_addr)) begin
        hit     = 1'b1;
        sel_idx = idx;
      end
    end
  end
endmodule

// File: rtl/sb_port.sv
module sb_port
  import sb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_ready,
  input  logic              fwd_hit,
  input  logic [DATA_W-1:0] fwd_data,
  input  logic              q_nonempty,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit
);
  logic              busy_q;
  logic [ADDR_W-1:0] pend_q;
  logic              ld_fire, rd_now;
  logic [ADDR_W-1:0] rd_addr;
  port_use_e         use_c;

  assign ld_ready = !busy_q;
  assign ld_fire  = ld_valid && !busy_q;
  assign rd_now   = busy_q || (ld_fire && !fwd_hit);
  assign rd_addr  = busy_q ? pend_q : ld_addr;

  always_comb begin
    if (rd_now)          use_c = PORT_READ;
    else if (q_nonempty) use_c = PORT_WRITE;
    else                 use_c = PORT_IDLE;
  end

  assign mem_req   = (use_c != PORT_IDLE);
  assign mem_we    = (use_c == PORT_WRITE);
  assign mem_addr  = (use_c == PORT_READ) ? rd_addr : head_addr;
  assign mem_wdata = head_data;
  assign pop       = (use_c == PORT_WRITE) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      pend_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      busy_q <= rd_now && !mem_ready;
      if (ld_fire) pend_q <= ld_addr;
      if (ld_fire && fwd_hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_data  <= fwd_data;
      end else if (rd_now && mem_ready) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_data  <= mem_rdata;
      end else begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && !fwd_hit) |-> !pop);  // R6
  AST_FWD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && fwd_hit) |=> (rsp_valid && rsp_hit));  // R4
  AST_MISS_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(mem_ready && mem_req && !mem_we));  // R5
  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && !mem_ready) |=> (mem_req && !mem_we && $stable(mem_addr)));  // R5
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_rsp_valid,
  output logic [DATA_W-1:0] ld_rsp_data,
  output logic              ld_rsp_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                         push, pop, fwd_hit;
  logic [PTR_W-1:0]             sel_idx, head_ptr;
  logic [CNT_W-1:0]             count;
  logic [DATA_W-1:0]            fwd_data, head_data;
  logic [ADDR_W-1:0]            head_addr;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_vec;

  assign st_ready = (count != CNT_W'(DEPTH));
  assign push     = st_valid && st_ready;
  assign empty    = (count == '0);

  sb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst(rst), .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .rd_idx(sel_idx), .rd_data(fwd_data), .head_data(head_data),
    .head_addr(head_addr), .head_ptr(head_ptr), .count(count), .addr_vec(addr_vec)
  );

  sb_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) match_i (
    .addr_vec(addr_vec), .head_ptr(head_ptr), .count(count), .q_addr(ld_addr),
    .hit(fwd_hit), .sel_idx(sel_idx)
  );

  sb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
    .fwd_hit(fwd_hit), .fwd_data(fwd_data), .q_nonempty(!empty),
    .head_addr(head_addr), .head_data(head_data), .pop(pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rsp_valid(ld_rsp_valid), .rsp_data(ld_rsp_data), .rsp_hit(ld_rsp_hit)
  );

  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    empty |-> !(mem_req && mem_we));  // R8
  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && fwd_hit) |-> !(mem_req && !mem_we));  // R4
  AST_STALLED_STORE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready && !pop) |=> !st_ready);  // R3
endmodule

// File: tb/store_fwd_buffer_tb.sv
`timescale 1ns/1ps
module store_fwd_buffer_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 0, ld_valid = 0, mem_ready = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, ld_ready, ld_rsp_valid, ld_rsp_hit, mem_req, mem_we, empty;
  logic [DW-1:0] ld_rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  logic [DW-1:0] memarr [256];
  assign mem_rdata = memarr[mem_addr];

  store_fwd_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data), .ld_rsp_hit(ld_rsp_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .empty(empty)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t sq[$];
  bit m_busy = 0;
  logic [AW-1:0] m_pend = '0;
  bit m_rv = 0, m_rh = 0;
  logic [DW-1:0] m_rd = '0;
  int compared = 0, mismatched = 0, r7_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic lv, input logic [AW-1:0] la, input logic mr);
    int n;
    bit lfire, hit, luse, drain;
    logic [DW-1:0] hd;
    logic [AW-1:0] raddr;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    ld_valid = lv; ld_addr = la; mem_ready = mr;
    #1;
    n = sq.size();
    lfire = lv && !m_busy;
    hit = 0; hd = '0;
    for (int k = 0; k < n; k++) if (sq[k].a == la) begin hit = 1; hd = sq[k].d; end
    luse = m_busy || (lfire && !hit);
    raddr = m_busy ? m_pend : la;
    drain = !luse && (n > 0);
    chk(empty == (n == 0), "R8 empty", 32'(empty), 32'(n == 0));
    chk(st_ready == (n < DEPTH), "R3 st_ready", 32'(st_ready), 32'(n < DEPTH));
    chk(ld_ready == !m_busy, "R9 ld_ready", 32'(ld_ready), 32'(!m_busy));
    chk(ld_rsp_valid == m_rv, "R4 rsp_valid", 32'(ld_rsp_valid), 32'(m_rv));
    if (m_rv) begin
      chk(ld_rsp_hit == m_rh, "R5 rsp_hit", 32'(ld_rsp_hit), 32'(m_rh));
      chk(ld_rsp_data == m_rd, "R4 rsp_data", 32'(ld_rsp_data), 32'(m_rd));
    end
    chk(mem_req == (luse || drain), "R10 mem_req", 32'(mem_req), 32'(luse || drain));
    if (luse || drain) begin
      chk(mem_we == drain, "R6 mem_we", 32'(mem_we), 32'(drain));
      chk(mem_addr == (luse ? raddr : sq[0].a), "R2 mem_addr", 32'(mem_addr),
          32'(luse ? raddr : sq[0].a));
      if (drain) chk(mem_wdata == sq[0].d, "R2 mem_wdata", 32'(mem_wdata), 32'(sq[0].d));
    end
    @(posedge clk); #1;
    if (lfire && hit) begin m_rv = 1; m_rh = 1; m_rd = hd; end
    else if (luse && mr) begin
      m_rv = 1; m_rh = 0; m_rd = memarr[raddr];
      if (n > 0) r7_seen++;
    end else m_rv = 0;
    if (drain && mr) begin memarr[sq[0].a] = sq[0].d; void'(sq.pop_front()); end
    if (sv && n < DEPTH) sq.push_back('{a: sa, d: sd});
    m_busy = luse && !mr;
    if (lfire) m_pend = la;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) memarr[i] = DW'(i * 37 + 11);
    repeat (3) @(posedge clk);
    #1;
    chk(empty && st_ready && ld_ready && !ld_rsp_valid && !mem_req, "R1 in reset",
        {27'd0, empty, st_ready, ld_ready, ld_rsp_valid, mem_req}, 32'b11100);
    @(negedge clk); rst = 0; #1;
    chk(empty && st_ready && ld_ready && !ld_rsp_valid && !mem_req, "R1 after reset",
        {27'd0, empty, st_ready, ld_ready, ld_rsp_valid, mem_req}, 32'b11100);

    // fill the buffer with memory stalled; address 10 twice
    step(1, 8'h10, 16'hA001, 0, 8'h00, 0);
    step(1, 8'h20, 16'hA002, 0, 8'h00, 0);
    step(1, 8'h10, 16'hA003, 0, 8'h00, 0);
    step(1, 8'h30, 16'hA004, 0, 8'h00, 0);
    chk(!st_ready, "R3 full", 32'(st_ready), 32'd0);
    // stalled store offered, load hits youngest copy
    step(1, 8'h40, 16'hA005, 1, 8'h10, 0);
    chk(ld_rsp_valid && ld_rsp_hit && ld_rsp_data == 16'hA003, "R4 youngest",
        32'(ld_rsp_data), 32'hA003);
    // miss load overtakes buffered stores
    step(1, 8'h40, 16'hA005, 1, 8'h55, 0);
    chk(!ld_ready, "R9 busy", 32'(ld_ready), 32'd0);
    step(1, 8'h40, 16'hA005, 0, 8'h00, 0);
    step(1, 8'h40, 16'hA005, 0, 8'h00, 1);
    chk(ld_rsp_valid && !ld_rsp_hit && ld_rsp_data == memarr[8'h55] && !empty,
        "R7 overtake", 32'(ld_rsp_data), 32'(memarr[8'h55]));
    for (int i = 0; i < 8; i++) step(1, 8'h40, 16'hA005, 0, 8'h00, 1);
    for (int i = 0; i < 6; i++) step(0, 8'h00, 16'h0, 0, 8'h00, 1);
    chk(empty && memarr[8'h10] == 16'hA003 && memarr[8'h40] == 16'hA005,
        "R2 drained", 32'(memarr[8'h40]), 32'hA005);
    // same-cycle store and load to one address: load sees memory
    step(1, 8'h66, 16'hB001, 1, 8'h66, 1);
    chk(ld_rsp_valid && !ld_rsp_hit, "R9 same cycle", 32'(ld_rsp_hit), 32'd0);

    for (int i = 0; i < 6000; i++) begin
      step(($urandom % 2) == 0, AW'($urandom % 8), DW'($urandom),
           ($urandom % 3) == 0, AW'($urandom % 8), ($urandom % 4) != 0);
    end
    for (int i = 0; i < 12; i++) step(0, 8'h00, 16'h0, 0, 8'h00, 1);
    chk(empty, "R8 final empty", 32'(empty), 32'd1);
    chk(r7_seen > 0, "R7 seen", 32'(r7_seen), 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule